// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block draws a small pointer image on top of the pixel stream that a display controller sends out. The controller supplies the current beam coordinates, the pixel colour and the sync and blank strobes. The block checks whether the beam lies inside the cursor square. When it does, the block takes a 2-bit code from its local bitmap RAM. That code either puts one of two programmable colours in place of the pixel, complements the pixel, or lets the pixel through unchanged.

A host loads the bitmap through a byte-wide write port. Two layouts of the bitmap are supported: a packed layout, with four pixels per byte, and a split-plane layout, in which every high bit is stored before every low bit. The programmed position can mark either the top-left or the bottom-right pixel of the square. Positions are two's-complement values, so the square can hang off the left or top edge of the screen. A new position only takes effect when vertical sync starts, so the pointer does not tear while it moves. After reset the RAM clears itself, so any part of the square the host never writes shows nothing.

Top module: `cursor_overlay`

## Requirements
- R1: out_hsync, out_vsync and out_blank repeat in_hsync, in_vsync and in_blank with a delay of exactly two clock cycles. out_pixel belongs to the input pixel from the same cycle.
- R2: While cfg_enable is low, out_pixel equals in_pixel from two cycles earlier, whatever the bitmap and position hold.
- R3: When in_blank is high, the pixel passes unchanged, even where the beam lies inside the cursor square.
- R4: Code meaning: 2'b11 selects cfg_fg, 2'b10 selects cfg_bg, 2'b01 outputs the bitwise complement of in_pixel, and 2'b00 passes in_pixel through.
- R5: Packed layout (cfg_planar=0): the pixel with index p = row*DIM + col sits in byte p/4, at bits [2*(p%4)+1 : 2*(p%4)].
- R6: Split-plane layout (cfg_planar=1): bit 1 of pixel p is bit p%8 of byte p/8. Bit 0 of pixel p is bit p%8 of byte DIM*DIM/8 + p/8.
- R7: With cfg_anchor_br=0 the square covers columns X to X+DIM-1 and rows Y to Y+DIM-1, where (X, Y) is the active position. With cfg_anchor_br=1 it covers X-DIM+1 to X and Y-DIM+1 to Y.
- R8: The active position loads cfg_pos_x and cfg_pos_y only in a cycle where in_vsync is high and was low in the cycle before. A change at any other time has no effect on the drawn image until that event.
- R9: cfg_pos_x and cfg_pos_y are two's-complement values. When the square extends past the left, top, right or bottom edge of the scanned area, its visible part is still drawn at the correct offsets.
- R10: For DIM*DIM/4 cycles after reset release, the RAM fills itself with zeros (code 00, transparent) and ignores host writes. Any byte the host does not write afterwards stays transparent.
- R11: While rst_n is low, out_pixel, out_hsync, out_vsync and out_blank are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Cursor drawing on/off |
| cfg_planar | input | 1 | Bitmap layout: 0 packed, 1 split-plane |
| cfg_anchor_br | input | 1 | Position marks bottom-right pixel when 1, top-left when 0 |
| cfg_fg | input | COLOR_W | Colour for code 11 |
| cfg_bg | input | COLOR_W | Colour for code 10 |
| cfg_pos_x | input | COORD_W | Requested horizontal position, two's complement |
| cfg_pos_y | input | COORD_W | Requested vertical position, two's complement |
| host_we | input | 1 | Bitmap byte write strobe |
| host_addr | input | log2(DIM*DIM/4) | Bitmap byte address |
| host_data | input | 8 | Bitmap byte value |
| beam_x | input | COORD_W | Current column of the pixel stream |
| beam_y | input | COORD_W | Current row of the pixel stream |
| in_pixel | input | COLOR_W | Underlying pixel colour |
| in_hsync | input | 1 | Horizontal sync from the timing generator |
| in_vsync | input | 1 | Vertical sync from the timing generator |
| in_blank | input | 1 | Blanking interval flag |
| out_pixel | output | COLOR_W | Pixel after the cursor is merged in |
| out_hsync | output | 1 | Horizontal sync, delayed to match |
| out_vsync | output | 1 | Vertical sync, delayed to match |
| out_blank | output | 1 | Blank flag, delayed to match |

## Verification
The bench builds the block with DIM=8, COORD_W=8 and COLOR_W=12. With these values the whole bitmap is 16 bytes, and a 20 by 14 scan area fits the full square several times over. Every pixel of every scanned frame is compared against a model that reads a logical code image and an independently tracked active position. This covers every code, both layouts, both anchors, partial squares at all four screen edges, and the deferred position load. The small RAM also makes the post-reset clear short enough to test both ways: a write made during the clear window is dropped, and a reload that covers only part of the bitmap leaves the rest transparent.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    // 2-bit cursor pixel codes
    typedef enum logic [1:0] {
        CODE_CLEAR  = 2'b00,
        CODE_INVERT = 2'b01,
        CODE_BACK   = 2'b10,
        CODE_FORE   = 2'b11
    } cur_code_e;

endpackage

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram #(
    parameter  int BYTES = 1024,
    localparam int AW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_data,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [7:0]    rd_data_a,
    output logic [7:0]    rd_data_b
);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] addr;
    } clr_t;

    clr_t clr_d, clr_q;

    logic [7:0]    mem [BYTES];
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_a_q, rd_b_q;

    // Post-reset zero fill walks every byte once; host port is muted meanwhile
    always_comb begin
        clr_d = clr_q;
        if (clr_q.busy) begin
            clr_d.addr = clr_q.addr + AW'(1);
            if (clr_q.addr == AW'(BYTES - 1)) begin
                clr_d.busy = 1'b0;
            end
        end
        if (clr_q.busy) begin
            wr_en   = 1'b1;
            wr_addr = clr_q.addr;
            wr_data = 8'h00;
        end else begin
            wr_en   = host_we;
            wr_addr = host_addr;
            wr_data = host_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= '{busy: 1'b1, addr: '0};
        end else begin
            clr_q <= clr_d;
        end
    end

    // Storage with registered dual read
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_a_q <= mem[rd_addr_a];
        rd_b_q <= mem[rd_addr_b];
    end

    assign rd_data_a = rd_a_q;
    assign rd_data_b = rd_b_q;

    AST_CLEAR_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q.busy && clr_q.addr != AW'(BYTES - 1)) |=> (clr_q.busy && clr_q.addr == $past(clr_q.addr) + AW'(1)))
        else $error("clear sweep skipped an address"); // R10

    AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q.busy && clr_q.addr == AW'(BYTES - 1)) |=> !clr_q.busy)
        else $error("clear sweep did not stop"); // R10

endmodule

// File: rtl/cursor_locator.sv
module cursor_locator #(
    parameter  int DIM     = 64,
    parameter  int COORD_W = 12,
    localparam int LD      = $clog2(DIM),
    localparam int IW      = 2 * LD,
    localparam int AW      = IW - 2,
    localparam int OW      = COORD_W + 2
) (
    input  logic               planar,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [COORD_W:0]   org_x,
    input  logic [COORD_W:0]   org_y,
    output logic               hit,
    output logic [AW-1:0]      addr_a,
    output logic [AW-1:0]      addr_b,
    output logic [2:0]         lane
);

    logic signed [OW-1:0] bx, by, ox, oy, dx, dy;
    logic        [IW-1:0] idx;

    always_comb begin
        bx  = {2'b00, beam_x};
        by  = {2'b00, beam_y};
        ox  = {org_x[COORD_W], org_x};
        oy  = {org_y[COORD_W], org_y};
        dx  = bx - ox;
        dy  = by - oy;
        hit = (dx >= 0) && (dx < $signed(OW'(DIM))) &&
              (dy >= 0) && (dy < $signed(OW'(DIM)));
        idx  = {dy[LD-1:0], dx[LD-1:0]};
        lane = idx[2:0];
        if (planar) begin
            addr_a = {1'b0, idx[IW-1:3]};
            addr_b = {1'b1, idx[IW-1:3]};
        end else begin
            addr_a = idx[IW-1:2];
            addr_b = idx[IW-1:2];
        end
    end

endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
    import cursor_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               draw,
    input  logic               planar,
    input  logic [2:0]         lane,
    input  logic [COLOR_W-1:0] pixel,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               blank,
    input  logic [7:0]         byte_a,
    input  logic [7:0]         byte_b,
    input  logic [COLOR_W-1:0] fg,
    input  logic [COLOR_W-1:0] bg,
    output logic [COLOR_W-1:0] out_pixel,
    output logic               out_hsync,
    output logic               out_vsync,
    output logic               out_blank
);

    typedef struct packed {
        logic [COLOR_W-1:0] pixel;
        logic               hsync;
        logic               vsync;
        logic               blank;
    } mix_t;

    mix_t      o_d, o_q;
    cur_code_e code;

    always_comb begin
        if (planar) begin
            code = cur_code_e'({byte_a[lane], byte_b[lane]});
        end else begin
            code = cur_code_e'(byte_a[{lane[1:0], 1'b0} +: 2]);
        end
        o_d.hsync = hsync;
        o_d.vsync = vsync;
        o_d.blank = blank;
        o_d.pixel = pixel;
        if (draw) begin
            case (code)
                CODE_FORE:   o_d.pixel = fg;
                CODE_BACK:   o_d.pixel = bg;
                CODE_INVERT: o_d.pixel = ~pixel;
                default:     o_d.pixel = pixel;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_pixel = o_q.pixel;
    assign out_hsync = o_q.hsync;
    assign out_vsync = o_q.vsync;
    assign out_blank = o_q.blank;

    AST_CODE_FORE: assert property (@(posedge clk) disable iff (!rst_n)
        (draw && code == CODE_FORE) |=> (out_pixel == $past(fg)))
        else $error("foreground code mis-rendered"); // R4

    AST_CODE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (draw && code == CODE_BACK) |=> (out_pixel == $past(bg)))
        else $error("background code mis-rendered"); // R4

    AST_CODE_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (draw && code == CODE_INVERT) |=> (out_pixel == ~$past(pixel)))
        else $error("invert code mis-rendered"); // R4

    AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_CLEAR) |=> (out_pixel == $past(pixel)))
        else $error("transparent code altered pixel"); // R4

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter  int DIM     = 64,
    parameter  int COORD_W = 12,
    parameter  int COLOR_W = 24,
    localparam int BYTES   = DIM * DIM / 4,
    localparam int AW      = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_planar,
    input  logic               cfg_anchor_br,
    input  logic [COLOR_W-1:0] cfg_fg,
    input  logic [COLOR_W-1:0] cfg_bg,
    input  logic [COORD_W-1:0] cfg_pos_x,
    input  logic [COORD_W-1:0] cfg_pos_y,
    input  logic               host_we,
    input  logic [AW-1:0]      host_addr,
    input  logic [7:0]         host_data,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [COLOR_W-1:0] in_pixel,
    input  logic               in_hsync,
    input  logic               in_vsync,
    input  logic               in_blank,
    output logic [COLOR_W-1:0] out_pixel,
    output logic               out_hsync,
    output logic               out_vsync,
    output logic               out_blank
);

    typedef struct packed {
        logic [COORD_W-1:0] pos_x;
        logic [COORD_W-1:0] pos_y;
        logic               vs_prev;
        logic [1:0]         age;
        logic [COLOR_W-1:0] s1_pixel;
        logic               s1_hsync;
        logic               s1_vsync;
        logic               s1_blank;
        logic               s1_draw;
        logic               s1_planar;
        logic [2:0]         s1_lane;
    } ovl_t;

    ovl_t t_d, t_q;

    logic [COORD_W:0] org_x, org_y;
    logic [COORD_W:0] pos_ext_x, pos_ext_y;
    logic             loc_hit;
    logic [AW-1:0]    loc_addr_a, loc_addr_b;
    logic [2:0]       loc_lane;
    logic [7:0]       ram_a, ram_b;

    // Anchor resolution: origin is the top-left pixel of the square
    always_comb begin
        pos_ext_x = {t_q.pos_x[COORD_W-1], t_q.pos_x};
        pos_ext_y = {t_q.pos_y[COORD_W-1], t_q.pos_y};
        if (cfg_anchor_br) begin
            org_x = pos_ext_x - (COORD_W+1)'(DIM - 1);
            org_y = pos_ext_y - (COORD_W+1)'(DIM - 1);
        end else begin
            org_x = pos_ext_x;
            org_y = pos_ext_y;
        end
    end

    cursor_locator #(
        .DIM     (DIM),
        .COORD_W (COORD_W)
    ) u_locator (
        .planar (cfg_planar),
        .beam_x (beam_x),
        .beam_y (beam_y),
        .org_x  (org_x),
        .org_y  (org_y),
        .hit    (loc_hit),
        .addr_a (loc_addr_a),
        .addr_b (loc_addr_b),
        .lane   (loc_lane)
    );

    cursor_bitmap_ram #(
        .BYTES (BYTES)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_data (host_data),
        .rd_addr_a (loc_addr_a),
        .rd_addr_b (loc_addr_b),
        .rd_data_a (ram_a),
        .rd_data_b (ram_b)
    );

    always_comb begin
        t_d         = t_q;
        t_d.vs_prev = in_vsync;
        if (in_vsync && !t_q.vs_prev) begin
            t_d.pos_x = cfg_pos_x;
            t_d.pos_y = cfg_pos_y;
        end
        if (t_q.age != 2'd2) begin
            t_d.age = t_q.age + 2'd1;
        end
        t_d.s1_pixel  = in_pixel;
        t_d.s1_hsync  = in_hsync;
        t_d.s1_vsync  = in_vsync;
        t_d.s1_blank  = in_blank;
        t_d.s1_draw   = loc_hit && cfg_enable && !in_blank;
        t_d.s1_planar = cfg_planar;
        t_d.s1_lane   = loc_lane;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    cursor_mixer #(
        .COLOR_W (COLOR_W)
    ) u_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .draw      (t_q.s1_draw),
        .planar    (t_q.s1_planar),
        .lane      (t_q.s1_lane),
        .pixel     (t_q.s1_pixel),
        .hsync     (t_q.s1_hsync),
        .vsync     (t_q.s1_vsync),
        .blank     (t_q.s1_blank),
        .byte_a    (ram_a),
        .byte_b    (ram_b),
        .fg        (cfg_fg),
        .bg        (cfg_bg),
        .out_pixel (out_pixel),
        .out_hsync (out_hsync),
        .out_vsync (out_vsync),
        .out_blank (out_blank)
    );

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.age == 2'd2) |-> (out_hsync == $past(in_hsync, 2) &&
                               out_vsync == $past(in_vsync, 2) &&
                               out_blank == $past(in_blank, 2)))
        else $error("sync strobes misaligned"); // R1

    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.age == 2'd2 && !$past(cfg_enable, 2)) |-> (out_pixel == $past(in_pixel, 2)))
        else $error("disabled cursor altered pixel"); // R2

    AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.age == 2'd2 && $past(in_blank, 2)) |-> (out_pixel == $past(in_pixel, 2)))
        else $error("blank pixel altered"); // R3

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_vsync && !t_q.vs_prev) |=> ($stable(t_q.pos_x) && $stable(t_q.pos_y)))
        else $error("position moved outside retrace"); // R8

endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;

    localparam int DIM     = 8;
    localparam int COORD_W = 8;
    localparam int COLOR_W = 12;
    localparam int BYTES   = DIM * DIM / 4;
    localparam int AW      = $clog2(BYTES);
    localparam int SCR_W   = 20;
    localparam int SCR_H   = 14;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cfg_enable, cfg_planar, cfg_anchor_br;
    logic [COLOR_W-1:0] cfg_fg, cfg_bg;
    logic [COORD_W-1:0] cfg_pos_x, cfg_pos_y;
    logic               host_we;
    logic [AW-1:0]      host_addr;
    logic [7:0]         host_data;
    logic [COORD_W-1:0] beam_x, beam_y;
    logic [COLOR_W-1:0] in_pixel;
    logic               in_hsync, in_vsync, in_blank;
    logic [COLOR_W-1:0] out_pixel;
    logic               out_hsync, out_vsync, out_blank;

    cursor_overlay #(
        .DIM     (DIM),
        .COORD_W (COORD_W),
        .COLOR_W (COLOR_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable    (cfg_enable),
        .cfg_planar    (cfg_planar),
        .cfg_anchor_br (cfg_anchor_br),
        .cfg_fg        (cfg_fg),
        .cfg_bg        (cfg_bg),
        .cfg_pos_x     (cfg_pos_x),
        .cfg_pos_y     (cfg_pos_y),
        .host_we       (host_we),
        .host_addr     (host_addr),
        .host_data     (host_data),
        .beam_x        (beam_x),
        .beam_y        (beam_y),
        .in_pixel      (in_pixel),
        .in_hsync      (in_hsync),
        .in_vsync      (in_vsync),
        .in_blank      (in_blank),
        .out_pixel     (out_pixel),
        .out_hsync     (out_hsync),
        .out_vsync     (out_vsync),
        .out_blank     (out_blank)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0]           img [DIM*DIM];
    int                   act_x, act_y;
    bit                   vs_prev_b;
    logic [COLOR_W+2:0]   h_exp [2];
    bit                   h_val [2];
    string                h_tag [2];

    function automatic logic [COLOR_W-1:0] pix_of(int x, int y);
        return COLOR_W'((x * 37 + y * 11 + 5) % 4096);
    endfunction

    function automatic logic [COLOR_W-1:0] model(int x, int y, logic [COLOR_W-1:0] pix, bit bl);
        int ox, oy, dx, dy;
        if (bl || !cfg_enable) return pix;
        ox = cfg_anchor_br ? act_x - (DIM - 1) : act_x;
        oy = cfg_anchor_br ? act_y - (DIM - 1) : act_y;
        dx = x - ox;
        dy = y - oy;
        if (dx < 0 || dx >= DIM || dy < 0 || dy >= DIM) return pix;
        case (img[dy * DIM + dx])
            2'b11:   return cfg_fg;
            2'b10:   return cfg_bg;
            2'b01:   return ~pix;
            default: return pix;
        endcase
    endfunction

    task automatic step(int x, int y, bit hs, bit vs, bit bl, string tag);
        logic [COLOR_W-1:0] p;
        @(negedge clk);
        if (h_val[1]) begin
            checks++;
            if ({out_pixel, out_hsync, out_vsync, out_blank} !== h_exp[1]) begin
                errors++;
                $display("FAIL %s R1 pixel/hs/vs/blank: actual %h expected %h", h_tag[1],
                         {out_pixel, out_hsync, out_vsync, out_blank}, h_exp[1]);
            end
        end
        h_exp[1] = h_exp[0];
        h_val[1] = h_val[0];
        h_tag[1] = h_tag[0];
        p        = pix_of(x, y);
        beam_x   = COORD_W'(x);
        beam_y   = COORD_W'(y);
        in_pixel = p;
        in_hsync = hs;
        in_vsync = vs;
        in_blank = bl;
        h_exp[0] = {model(x, y, p, bl), hs, vs, bl};
        h_val[0] = 1'b1;
        h_tag[0] = tag;
        if (vs && !vs_prev_b) begin
            act_x = int'($signed(cfg_pos_x));
            act_y = int'($signed(cfg_pos_y));
        end
        vs_prev_b = vs;
    endtask

    task automatic frame(string tag, bit with_vs, bit all_blank);
        if (with_vs) begin
            for (int i = 0; i < 3; i++) step(0, 0, 1'b0, 1'b1, 1'b1, tag);
            for (int i = 0; i < 2; i++) step(0, 0, 1'b0, 1'b0, 1'b1, tag);
        end
        for (int y = 0; y < SCR_H; y++) begin
            for (int x = 0; x < SCR_W; x++) step(x, y, 1'b0, 1'b0, all_blank, tag);
            step(0, y, 1'b1, 1'b0, 1'b1, tag);
        end
        step(0, 0, 1'b0, 1'b0, 1'b1, tag);
        step(0, 0, 1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic write_byte(int a, logic [7:0] d);
        h_val[0] = 1'b0;
        h_val[1] = 1'b0;
        @(negedge clk);
        host_we   = 1'b1;
        host_addr = AW'(a);
        host_data = d;
        @(negedge clk);
        host_we   = 1'b0;
    endtask

    task automatic load_packed(int nbytes);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] v;
            for (int k = 0; k < 4; k++) v[2*k +: 2] = img[4*b + k];
            write_byte(b, v);
        end
    endtask

    task automatic load_planar();
        for (int b = 0; b < BYTES / 2; b++) begin
            logic [7:0] hi, lo;
            for (int j = 0; j < 8; j++) begin
                hi[j] = img[8*b + j][1];
                lo[j] = img[8*b + j][0];
            end
            write_byte(b, hi);
            write_byte(BYTES / 2 + b, lo);
        end
    endtask

    task automatic do_reset();
        h_val[0] = 1'b0;
        h_val[1] = 1'b0;
        @(negedge clk);
        rst_n    = 1'b0;
        in_pixel = '1;
        in_hsync = 1'b1;
        in_vsync = 1'b1;
        in_blank = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_pixel, out_hsync, out_vsync, out_blank} !== '0) begin
            errors++;
            $display("FAIL R11 reset outputs: actual %h expected 0",
                     {out_pixel, out_hsync, out_vsync, out_blank});
        end
        in_hsync  = 1'b0;
        in_vsync  = 1'b0;
        vs_prev_b = 1'b0;
        act_x     = 0;
        act_y     = 0;
        rst_n     = 1'b1;
        // R10: this write falls inside the clear window and must be dropped
        host_we   = 1'b1;
        host_addr = '0;
        host_data = 8'hFF;
        @(negedge clk);
        host_we   = 1'b0;
        repeat (BYTES + 4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_planar = 1'b0; cfg_anchor_br = 1'b0;
        cfg_fg = 12'hF0F; cfg_bg = 12'h0A0;
        cfg_pos_x = '0; cfg_pos_y = '0;
        host_we = 1'b0; host_addr = '0; host_data = '0;
        beam_x = '0; beam_y = '0; in_pixel = '0;
        in_hsync = 1'b0; in_vsync = 1'b0; in_blank = 1'b1;
        h_val[0] = 1'b0; h_val[1] = 1'b0;
        for (int p = 0; p < DIM*DIM; p++) img[p] = 2'b00;

        do_reset();

        // R10: freshly cleared bitmap shows nothing
        cfg_enable = 1'b1;
        cfg_pos_x = 8'd3; cfg_pos_y = 8'd2;
        frame("R10 cleared bitmap", 1'b1, 1'b0);

        for (int p = 0; p < DIM*DIM; p++) img[p] = 2'((p + p / DIM) % 4);
        load_packed(BYTES);
        frame("R5 R4 R7 packed top-left", 1'b1, 1'b0);

        cfg_anchor_br = 1'b1;
        cfg_pos_x = 8'd12; cfg_pos_y = 8'd10;
        frame("R7 bottom-right anchor", 1'b1, 1'b0);

        cfg_anchor_br = 1'b0;
        cfg_pos_x = COORD_W'(-3); cfg_pos_y = COORD_W'(-5);
        frame("R9 negative position", 1'b1, 1'b0);

        cfg_pos_x = COORD_W'(-6); cfg_pos_y = 8'd9;
        frame("R9 left and bottom clip", 1'b1, 1'b0);

        cfg_pos_x = 8'd16; cfg_pos_y = 8'd1;
        frame("R9 right edge clip", 1'b1, 1'b0);

        // R8: new request without retrace must not move the square
        cfg_pos_x = 8'd10; cfg_pos_y = 8'd3;
        frame("R8 deferred position", 1'b0, 1'b0);
        frame("R8 applied at retrace", 1'b1, 1'b0);

        frame("R3 blanking pass", 1'b1, 1'b1);

        cfg_enable = 1'b0;
        frame("R2 disabled pass", 1'b1, 1'b0);

        cfg_enable = 1'b1;
        cfg_planar = 1'b1;
        load_planar();
        cfg_pos_x = 8'd5; cfg_pos_y = 8'd4;
        frame("R6 planar top-left", 1'b1, 1'b0);

        cfg_anchor_br = 1'b1;
        cfg_pos_x = 8'd19; cfg_pos_y = 8'd13;
        frame("R6 planar bottom-right", 1'b1, 1'b0);

        // R10: partial reload after reset leaves the rest transparent
        cfg_anchor_br = 1'b0;
        cfg_planar = 1'b0;
        do_reset();
        for (int p = 0; p < DIM*DIM; p++) img[p] = (p < DIM) ? 2'((p % 3) + 1) : 2'b00;
        load_packed(DIM / 4);
        cfg_pos_x = 8'd2; cfg_pos_y = 8'd3;
        frame("R10 partial image", 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule